// File: doc/BRIEF.md
# Windowed Watchdog Monitor with Refresh Key

This block supervises software liveness. Once enabled, an internal counter advances on every clock. Software keeps the monitor quiet by writing a two-byte key to the service register, and that refresh only counts when the counter sits inside a window set by a low and a high compare value. A refresh that comes too early, uses the wrong bytes, or leaves too long a pause between its bytes trips the monitor. So does a counter that runs past the high compare value, or an external trip pin held at its asserted level.

When tripped, the active-low output `trip_out_n` goes low and stays low until reset. An interrupt request follows the tripped state whenever the interrupt enable is set. The configuration bits and both compare values can be set once after reset. A later write that tries to change them is refused and flagged as a bus error.

The register interface is byte-wide with four offsets. Reads are combinational and return zero unless `bus_rd` is high.

Top module: `wdm_window_mon`

## Requirements
- R1: After reset the control register reads 0x00, compare-low reads 0x00, compare-high reads 0xFF, `trip_out_n` is 1, `irq` is 0 and `bus_err` is 0.
- R2: Offset 0 is control, with bit 0 enable, bit 1 trip-pin polarity, bit 2 trip-pin enable, bit 3 interrupt enable, and bits 7:4 reading 0. Offset 1 is service, which always reads 0x00. Offset 2 is compare-low and offset 3 is compare-high.
- R3: Control bits 2:0 are taken from the first control write and then locked. A later control write whose bits 2:0 differ from the locked value leaves them unchanged and makes `bus_err` high for the one cycle after the write. Bit 3 stays writable, and a write that keeps bits 2:0 gives no error.
- R4: Compare-low and compare-high each accept one write after reset. Any second write to either leaves its value unchanged and makes `bus_err` high for the one cycle after the write.
- R5: A first control write with bit 0 set clears the counter and the trip state. From then on the counter adds one per cycle and saturates at 0xFF. A monitor whose first control write has bit 0 clear never counts, never trips, and ignores service writes.
- R6: The monitor trips on the edge after the counter becomes greater than compare-high. With compare-high at 0xFF it never expires.
- R7: A refresh is a write of 0xB4 to service followed by a write of 0x2C. Any other byte in either place trips the monitor.
- R8: The second key byte must be written within GAP_LIMIT (default 15) cycles after the first. A wait of GAP_LIMIT+1 cycles or more trips the monitor.
- R9: A complete key while the counter is at or above compare-low resets the counter to 0. A complete key below compare-low trips the monitor.
- R10: With the trip-pin enable set, `trip_in` equal to the polarity bit (0 by default, 1 when bit 1 is set) trips the monitor on the next edge. With the trip-pin enable clear, `trip_in` has no effect.
- R11: Once tripped, `trip_out_n` stays 0 until reset, whatever is written afterwards.
- R12: `irq` is 1 exactly while the monitor is tripped and the interrupt enable is set. Clearing the interrupt enable drops `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when not reading |
| bus_err | output | 1 | One-cycle pulse for a refused write |
| trip_in | input | 1 | External trip pin |
| trip_out_n | output | 1 | Active-low trip output |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a key whose second byte lands exactly at the edge of a limit: at the gap limit, one cycle past it, or on a counter value equal to compare-low. The table-driven part of the bench places each key byte at a computed cycle offset from the enabling write, so the counter value at the second byte is known exactly. Each entry then gets its own reset, because both the configuration lock and the trip state are sticky.

// File: rtl/wdm_pkg.sv
package wdm_pkg;
    localparam int REG_W = 8;

    localparam logic [REG_W-1:0] KEY_FIRST  = 8'hB4;
    localparam logic [REG_W-1:0] KEY_SECOND = 8'h2C;

    typedef enum logic [1:0] {
        OFS_CTRL    = 2'd0,
        OFS_SERVICE = 2'd1,
        OFS_LOW     = 2'd2,
        OFS_HIGH    = 2'd3
    } ofs_e;

    typedef struct packed {
        logic inten;
        logic pin_en;
        logic pin_pol;
        logic en;
    } ctrl_t;
endpackage

// File: rtl/wdm_regs.sv
module wdm_regs
    import wdm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic             bus_err,
    output ctrl_t            ctrl,
    output logic [REG_W-1:0] cmp_lo,
    output logic [REG_W-1:0] cmp_hi,
    output logic             restart
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic             ctrl_lk;
        logic [REG_W-1:0] lo;
        logic             lo_lk;
        logic [REG_W-1:0] hi;
        logic             hi_lk;
        logic             err;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.err = 1'b0;
        restart = 1'b0;
        if (bus_wr) begin
            case (ofs_e'(bus_addr))
                OFS_CTRL: begin
                    if (!r_q.ctrl_lk) begin
                        r_d.ctrl    = ctrl_t'(bus_wdata[3:0]);
                        r_d.ctrl_lk = 1'b1;
                        restart     = bus_wdata[0];
                    end else begin
                        r_d.ctrl.inten = bus_wdata[3];
                        if (bus_wdata[2:0] != r_q.ctrl[2:0]) r_d.err = 1'b1;
                    end
                end
                OFS_LOW: begin
                    if (!r_q.lo_lk) begin
                        r_d.lo    = bus_wdata;
                        r_d.lo_lk = 1'b1;
                    end else begin
                        r_d.err = 1'b1;
                    end
                end
                OFS_HIGH: begin
                    if (!r_q.hi_lk) begin
                        r_d.hi    = bus_wdata;
                        r_d.hi_lk = 1'b1;
                    end else begin
                        r_d.err = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.hi <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (ofs_e'(bus_addr))
                OFS_CTRL: bus_rdata = {{(REG_W-4){1'b0}}, r_q.ctrl};
                OFS_LOW:  bus_rdata = r_q.lo;
                OFS_HIGH: bus_rdata = r_q.hi;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign bus_err = r_q.err;
    assign ctrl    = r_q.ctrl;
    assign cmp_lo  = r_q.lo;
    assign cmp_hi  = r_q.hi;
endmodule

// File: rtl/wdm_key.sv
module wdm_key
    import wdm_pkg::*;
#(
    parameter int GAP_LIMIT = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             svc_wr,
    input  logic [REG_W-1:0] svc_data,
    output logic             key_done,
    output logic             key_bad
);
    localparam int GAP_W = $clog2(GAP_LIMIT + 1);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_LIMIT - 1);

    typedef struct packed {
        logic             armed;
        logic [GAP_W-1:0] gap;
    } key_t;

    key_t k_d, k_q;

    always_comb begin
        k_d      = k_q;
        key_done = 1'b0;
        key_bad  = 1'b0;
        if (!active) begin
            k_d.armed = 1'b0;
        end else if (svc_wr) begin
            if (!k_q.armed) begin
                if (svc_data == KEY_FIRST) begin
                    k_d.armed = 1'b1;
                    k_d.gap   = '0;
                end else begin
                    key_bad = 1'b1;
                end
            end else begin
                k_d.armed = 1'b0;
                if (svc_data == KEY_SECOND) key_done = 1'b1;
                else                        key_bad  = 1'b1;
            end
        end else if (k_q.armed) begin
            if (k_q.gap == GAP_LAST) begin
                key_bad   = 1'b1;
                k_d.armed = 1'b0;
            end else begin
                k_d.gap = k_q.gap + GAP_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) k_q <= '0;
        else        k_q <= k_d;
    end
endmodule

// File: rtl/wdm_count.sv
module wdm_count
    import wdm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             restart,
    input  logic             key_done,
    input  logic             key_bad,
    input  logic             pin_hit,
    input  logic [REG_W-1:0] cmp_lo,
    input  logic [REG_W-1:0] cmp_hi,
    output logic [REG_W-1:0] cnt,
    output logic             tripped
);
    typedef struct packed {
        logic [REG_W-1:0] cnt;
        logic             trip;
    } cnt_t;

    cnt_t c_d, c_q;
    logic expire, early;

    always_comb begin
        c_d    = c_q;
        expire = c_q.cnt > cmp_hi;
        early  = key_done && (c_q.cnt < cmp_lo);
        if (restart) begin
            c_d.cnt  = '0;
            c_d.trip = 1'b0;
        end else if (active) begin
            if (key_done && !early)  c_d.cnt = '0;
            else if (c_q.cnt != '1)  c_d.cnt = c_q.cnt + REG_W'(1);
            if (expire || early || key_bad || pin_hit) c_d.trip = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cnt     = c_q.cnt;
    assign tripped = c_q.trip;
endmodule

// File: rtl/wdm_window_mon.sv
module wdm_window_mon
    import wdm_pkg::*;
#(
    parameter int GAP_LIMIT = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic             bus_err,
    input  logic             trip_in,
    output logic             trip_out_n,
    output logic             irq
);
    ctrl_t            ctrl;
    logic [REG_W-1:0] cmp_lo, cmp_hi, cnt;
    logic             restart, key_done, key_bad, pin_hit, tripped, svc_wr;

    wdm_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .ctrl(ctrl), .cmp_lo(cmp_lo), .cmp_hi(cmp_hi),
        .restart(restart)
    );

    assign svc_wr = bus_wr && (ofs_e'(bus_addr) == OFS_SERVICE);

    wdm_key #(.GAP_LIMIT(GAP_LIMIT)) u_key (
        .clk(clk), .rst_n(rst_n), .active(ctrl.en), .svc_wr(svc_wr),
        .svc_data(bus_wdata), .key_done(key_done), .key_bad(key_bad)
    );

    assign pin_hit = ctrl.pin_en && (trip_in == ctrl.pin_pol);

    wdm_count u_count (
        .clk(clk), .rst_n(rst_n), .active(ctrl.en), .restart(restart),
        .key_done(key_done), .key_bad(key_bad), .pin_hit(pin_hit),
        .cmp_lo(cmp_lo), .cmp_hi(cmp_hi), .cnt(cnt), .tripped(tripped)
    );

    assign trip_out_n = ~tripped;
    assign irq        = tripped && ctrl.inten;
endmodule

// File: rtl/wdm_chk.sv
module wdm_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_rd,
    input logic [1:0]   bus_addr,
    input logic [W-1:0] bus_rdata,
    input logic         trip_out_n,
    input logic         irq,
    input logic [W-1:0] cnt,
    input logic         restart,
    input logic         active
);
    a_r11_out_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !trip_out_n |=> !trip_out_n);

    a_r12_irq_needs_trip: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !trip_out_n);

    a_r2_service_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd1) |-> bus_rdata == '0);

    a_r5_restart_clean: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0 && trip_out_n));

    a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cnt == '1) |=> (cnt == '1 || cnt == '0));

    a_r5_count_up_or_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cnt != '0) |=> (cnt == '0 || cnt >= $past(cnt)));

    a_r5_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !restart) |=> $stable(cnt));
endmodule

bind wdm_window_mon wdm_chk #(.W(wdm_pkg::REG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .trip_out_n(trip_out_n), .irq(irq),
    .cnt(cnt), .restart(restart), .active(ctrl.en)
);

// File: tb/tb_wdm_window_mon.sv
`timescale 1ns/1ps
module tb_wdm_window_mon;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       bus_err, trip_in = 1'b1, trip_out_n, irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    wdm_window_mon dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .trip_in(trip_in), .trip_out_n(trip_out_n),
        .irq(irq)
    );

    // Entry fields: cmp_lo, cmp_hi, wait, byte1, gap, byte2, expect_trip
    localparam logic [55:0] VEC [10] = '{
        {8'd0,  8'hFF, 8'd5, 8'hB4, 8'd0,  8'h2C, 8'd0}, // R7 legal key
        {8'd0,  8'hFF, 8'd5, 8'hB4, 8'd14, 8'h2C, 8'd0}, // R8 gap at limit
        {8'd0,  8'hFF, 8'd5, 8'hB4, 8'd15, 8'h2C, 8'd1}, // R8 gap over limit
        {8'd0,  8'hFF, 8'd5, 8'hB4, 8'd0,  8'h2D, 8'd1}, // R7 wrong second
        {8'd0,  8'hFF, 8'd5, 8'hB5, 8'd0,  8'h2C, 8'd1}, // R7 wrong first
        {8'd20, 8'hFF, 8'd5, 8'hB4, 8'd0,  8'h2C, 8'd1}, // R9 too early
        {8'd6,  8'hFF, 8'd5, 8'hB4, 8'd0,  8'h2C, 8'd0}, // R9 equal to low
        {8'd7,  8'hFF, 8'd5, 8'hB4, 8'd0,  8'h2C, 8'd1}, // R9 one below low
        {8'd0,  8'd10, 8'd5, 8'hB4, 8'd3,  8'h2C, 8'd0}, // R9 near high
        {8'd0,  8'hFF, 8'd5, 8'h2C, 8'd0,  8'hB4, 8'd1}  // R7 swapped order
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; trip_in = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;

        // Table walk: R7 R8 R9
        for (int i = 0; i < 10; i++) begin
            do_reset();
            wr(2'd2, VEC[i][55:48]);
            wr(2'd3, VEC[i][47:40]);
            wr(2'd0, 8'h01);
            repeat (VEC[i][39:32]) @(negedge clk);
            wr(2'd1, VEC[i][31:24]);
            repeat (VEC[i][23:16]) @(negedge clk);
            wr(2'd1, VEC[i][15:8]);
            @(negedge clk);
            chk($sformatf("R7/R8/R9 vector %0d trip_out_n", i),
                {7'd0, trip_out_n}, {7'd0, ~VEC[i][0]});
        end

        // R1 reset values
        do_reset();
        rd(2'd0, v); chk("R1 ctrl reset", v, 8'h00);
        rd(2'd2, v); chk("R1 low reset", v, 8'h00);
        rd(2'd3, v); chk("R1 high reset", v, 8'hFF);
        chk("R1 out reset", {7'd0, trip_out_n}, 8'd1);
        chk("R1 irq reset", {7'd0, irq}, 8'd0);
        chk("R1 err reset", {7'd0, bus_err}, 8'd0);

        // R2 layout, R5 disabled monitor, R3 lock
        wr(2'd1, 8'h55);
        rd(2'd1, v); chk("R2 service reads zero", v, 8'h00);
        wr(2'd0, 8'hF2);
        rd(2'd0, v); chk("R2 reserved bits read zero", v, 8'h02);
        wr(2'd3, 8'd3);
        repeat (20) @(negedge clk);
        chk("R5 disabled never trips", {7'd0, trip_out_n}, 8'd1);
        wr(2'd0, 8'h03);
        chk("R3 enable after lock errors", {7'd0, bus_err}, 8'd1);
        rd(2'd0, v); chk("R3 locked bits kept", v, 8'h02);

        // R6 exact expiry timing, R11 stickiness, R3 same-value write
        do_reset();
        wr(2'd3, 8'd10);
        wr(2'd0, 8'h01);
        repeat (11) @(negedge clk);
        chk("R6 not yet expired", {7'd0, trip_out_n}, 8'd1);
        @(negedge clk);
        chk("R6 expired", {7'd0, trip_out_n}, 8'd0);
        wr(2'd0, 8'h01);
        chk("R3 same-value write no error", {7'd0, bus_err}, 8'd0);
        wr(2'd1, 8'hB4);
        wr(2'd1, 8'h2C);
        repeat (20) @(negedge clk);
        chk("R11 output sticky", {7'd0, trip_out_n}, 8'd0);

        // R4 write-once compares
        do_reset();
        wr(2'd2, 8'd5);
        chk("R4 first low write ok", {7'd0, bus_err}, 8'd0);
        wr(2'd2, 8'd7);
        chk("R4 second low write errors", {7'd0, bus_err}, 8'd1);
        @(negedge clk);
        chk("R4 error is one cycle", {7'd0, bus_err}, 8'd0);
        rd(2'd2, v); chk("R4 low value kept", v, 8'd5);
        wr(2'd3, 8'd9);
        wr(2'd3, 8'd9);
        chk("R4 second high write errors", {7'd0, bus_err}, 8'd1);

        // R5/R6 saturation with high at 0xFF
        do_reset();
        wr(2'd0, 8'h01);
        repeat (300) @(negedge clk);
        chk("R6 high 0xFF never expires", {7'd0, trip_out_n}, 8'd1);

        // R9 refresh clears counter
        do_reset();
        wr(2'd3, 8'd10);
        wr(2'd0, 8'h01);
        repeat (6) @(negedge clk);
        wr(2'd1, 8'hB4);
        wr(2'd1, 8'h2C);
        repeat (10) @(negedge clk);
        chk("R9 refresh delays expiry", {7'd0, trip_out_n}, 8'd1);
        repeat (3) @(negedge clk);
        chk("R9 expiry after refresh", {7'd0, trip_out_n}, 8'd0);

        // R10 trip pin
        do_reset();
        wr(2'd0, 8'h05);
        repeat (5) @(negedge clk);
        chk("R10 pin idle high", {7'd0, trip_out_n}, 8'd1);
        trip_in = 1'b0;
        @(negedge clk);
        chk("R10 pin low trips", {7'd0, trip_out_n}, 8'd0);

        do_reset();
        wr(2'd0, 8'h07);
        trip_in = 1'b0;
        repeat (5) @(negedge clk);
        chk("R10 inverted pin idle low", {7'd0, trip_out_n}, 8'd1);
        trip_in = 1'b1;
        @(negedge clk);
        chk("R10 inverted pin high trips", {7'd0, trip_out_n}, 8'd0);

        do_reset();
        wr(2'd0, 8'h01);
        trip_in = 1'b0;
        repeat (5) @(negedge clk);
        chk("R10 pin ignored when disabled", {7'd0, trip_out_n}, 8'd1);

        // R12 interrupt
        do_reset();
        wr(2'd0, 8'h0D);
        rd(2'd0, v); chk("R2 ctrl readback", v, 8'h0D);
        chk("R12 irq idle", {7'd0, irq}, 8'd0);
        trip_in = 1'b0;
        @(negedge clk);
        chk("R12 irq raised", {7'd0, irq}, 8'd1);
        wr(2'd0, 8'h05);
        chk("R12 irq cleared", {7'd0, irq}, 8'd0);
        chk("R3 inten change no error", {7'd0, bus_err}, 8'd0);
        chk("R11 out stays low", {7'd0, trip_out_n}, 8'd0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule